// File: doc/BRIEF.md
# Lockable Protected-RAM Access Control Register

This block holds the one-byte control register that decides how a protected region of system RAM is reached. Four fields matter to the memory decoder. An open field makes the region visible to ordinary accesses. A closed field hides it from data accesses. A lock field freezes the controls. A global enable field switches the protected region on at all. Software reaches the byte through a plain byte-wide configuration port with separate read and write strobes. The decoder takes the field values straight from dedicated output pins.

The lock field can only be set. The write that sets it also forces the open field to zero. After that, no software write can raise the open field or change the global enable, and the lock itself stays set. Only a synchronous hardware reset brings the register back to all zeros, and after that the open field can be set again. The closed field stays writable whether the register is locked or not.

Bit positions:

| Bit | Field |
|-----|-------|
| 6 | open |
| 5 | closed |
| 4 | lock |
| 3 | global enable |
| 7, 2..0 | reserved |

Top module: `smram_ctrl_reg`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every register bit, every decoder output and `cfg_rdata` become 0.
- R2: While the lock field is 0, a write sets or clears the open field (bit 6) to the written value, and a later read returns it.
- R3: A write with bit 4 set sets the lock field and leaves the open field at 0, even if the same byte has bit 6 set.
- R4: While locked, a write with bit 6 set leaves the open field at 0, and it reads back as 0.
- R5: A write with bit 4 clear does not clear a set lock field; only reset clears it.
- R6: While locked, writes do not change the global enable field (bit 3).
- R7: The closed field (bit 5) takes the written value on every write, locked or not.
- R8: A read strobe sampled at a rising edge loads `cfg_rdata` with the register value before that edge. `cfg_rdata` holds its value while no read is strobed. Reserved bits 7 and 2..0 always read as 0.
- R9: After a reset that follows a lock, the lock field is 0 and the open field can be set again.
- R10: The outputs `dec_open`, `dec_closed`, `dec_lock` and `dec_global_en` show the register fields from the edge that stores a write onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for the register byte |
| cfg_wdata | input | 8 | Write data |
| cfg_rd_en | input | 1 | Read strobe |
| cfg_rdata | output | 8 | Registered read data |
| dec_open | output | 1 | Open field for the memory decoder |
| dec_closed | output | 1 | Closed field for the memory decoder |
| dec_lock | output | 1 | Lock field for the memory decoder |
| dec_global_en | output | 1 | Global enable field for the memory decoder |

## Verification
A write strobed at one rising edge is stored at that edge. The decoder outputs show the new fields right after it. A read strobed at an edge places the register value on `cfg_rdata` at that same edge. So a read issued in the cycle after a write sees the written value one edge later. Every bench task drives its strobes half a cycle before an edge and samples half a cycle after it, so each value is checked in the first cycle where it is due.

// File: rtl/smram_pkg.sv
// Package: field positions and the record of the protected-RAM control byte.
// Assumes an 8-bit register; the positions are decoded by the memory decoder.
package smram_pkg;
    localparam int unsigned REG_W    = 8;
    localparam int unsigned BIT_OPEN = 6;
    localparam int unsigned BIT_CLS  = 5;
    localparam int unsigned BIT_LOCK = 4;
    localparam int unsigned BIT_GEN  = 3;

    typedef struct packed {
        logic open;
        logic closed;
        logic lock;
        logic gen;
    } smram_fields_t;

    // Pack the fields into the byte layout; reserved bits are zero.
    function automatic logic [REG_W-1:0] pack_fields(smram_fields_t f);
        logic [REG_W-1:0] b;
        b = '0;
        b[BIT_OPEN] = f.open;
        b[BIT_CLS]  = f.closed;
        b[BIT_LOCK] = f.lock;
        b[BIT_GEN]  = f.gen;
        return b;
    endfunction
endpackage

// File: rtl/smram_next_state.sv
// Module: computes the next field values from the current state and a write.
// Assumes one write per cycle; the lock gates open and global enable.
module smram_next_state
    import smram_pkg::*;
(
    input  smram_fields_t     cur,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wdata,
    output smram_fields_t     nxt
);
    logic locked_after;

    // Purpose: the lock is sticky and is set by writing a one.
    assign locked_after = cur.lock | (wr_en & wdata[BIT_LOCK]);

    // Purpose: derive each field's next value under the lock rules.
    always_comb begin
        nxt = cur;
        if (wr_en) begin
            nxt.closed = wdata[BIT_CLS];
            nxt.lock   = locked_after;
            nxt.gen    = cur.lock ? cur.gen : wdata[BIT_GEN];
            nxt.open   = locked_after ? 1'b0 : wdata[BIT_OPEN];
        end
    end
endmodule

// File: rtl/smram_state_reg.sv
// Module: holds the field flops with synchronous active-low reset.
// Assumes rst_n is synchronous to clk.
module smram_state_reg
    import smram_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  smram_fields_t nxt,
    output smram_fields_t cur
);
    // Purpose: store the fields; reset clears all of them.
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= '0;
        else        cur <= nxt;
    end

    // R5
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur.lock |=> cur.lock);
    // R4
    open_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur.lock |-> !cur.open);
    // R6
    gen_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur.lock |=> $stable(cur.gen));
endmodule

// File: rtl/smram_ctrl_reg.sv
// Module: top of the protected-RAM control register with byte config port.
// Assumes at most one of read or write is meaningful per cycle; a read in the
// same cycle as a write returns the value before the write.
module smram_ctrl_reg
    import smram_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [7:0]       cfg_wdata,
    input  logic             cfg_rd_en,
    output logic [7:0]       cfg_rdata,
    output logic             dec_open,
    output logic             dec_closed,
    output logic             dec_lock,
    output logic             dec_global_en
);
    smram_fields_t cur_f, nxt_f;
    logic [REG_W-1:0] cur_byte;

    smram_next_state u_next (
        .cur   (cur_f),
        .wr_en (cfg_wr_en),
        .wdata (cfg_wdata),
        .nxt   (nxt_f)
    );

    smram_state_reg u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .nxt   (nxt_f),
        .cur   (cur_f)
    );

    // Purpose: byte image of the current fields.
    assign cur_byte = pack_fields(cur_f);

    // Purpose: registered read data, loaded on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         cfg_rdata <= '0;
        else if (cfg_rd_en) cfg_rdata <= cur_byte;
    end

    // Purpose: export fields to the memory decoder.
    assign dec_open      = cur_f.open;
    assign dec_closed    = cur_f.closed;
    assign dec_lock      = cur_f.lock;
    assign dec_global_en = cur_f.gen;

    // R8
    rd_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_en |=> cfg_rdata[BIT_OPEN] == $past(dec_open) &&
                      cfg_rdata[BIT_LOCK] == $past(dec_lock));
    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rd_en |=> $stable(cfg_rdata));
    // R8
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[7] == 1'b0 && cfg_rdata[2:0] == 3'b000);
    // R3
    lock_clears_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_wdata[BIT_LOCK]) |=> dec_lock && !dec_open);
    // R7
    closed_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en |=> dec_closed == $past(cfg_wdata[BIT_CLS]));
endmodule

// File: tb/tb_smram_ctrl_reg.sv
module tb_smram_ctrl_reg;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr_en = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic cfg_rd_en = 1'b0;
    logic [7:0] cfg_rdata;
    logic dec_open, dec_closed, dec_lock, dec_global_en;
    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    localparam logic [7:0] OPEN = 8'h40, CLS = 8'h20, LCK = 8'h10, GEN = 8'h08;

    smram_ctrl_reg dut (.*);

    always #10 clk = ~clk;

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_rd_en = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic wr(logic [7:0] d);
        @(negedge clk); cfg_wr_en = 1'b1; cfg_wdata = d;
        @(negedge clk); cfg_wr_en = 1'b0;
    endtask

    task automatic rd(output logic [7:0] d);
        @(negedge clk); cfg_rd_en = 1'b1;
        @(negedge clk); cfg_rd_en = 1'b0; d = cfg_rdata;
    endtask

    function automatic logic [7:0] outs();
        return {1'b0, dec_open, dec_closed, dec_lock, dec_global_en, 3'b000};
    endfunction

    task automatic t_reset();
        logic [7:0] v;
        check("R1 outputs", outs(), 8'h00);
        check("R1 rdata", cfg_rdata, 8'h00);
        rd(v); check("R1 read", v, 8'h00);
    endtask

    task automatic t_unlocked();
        logic [7:0] v;
        wr(OPEN); check("R10 open out", outs(), OPEN);
        rd(v); check("R2 set open", v, OPEN);
        wr(8'h00); rd(v); check("R2 clear open", v, 8'h00);
        wr(8'hFF & ~LCK); rd(v); check("R8 reserved zero", v, OPEN | CLS | GEN);
        wr(OPEN); @(negedge clk); @(negedge clk);
        check("R8 rdata holds", cfg_rdata, OPEN | CLS | GEN);
    endtask

    task automatic t_lock();
        logic [7:0] v;
        wr(OPEN | GEN); rd(v); check("R2 pre-lock", v, OPEN | GEN);
        wr(OPEN | LCK | GEN); check("R3 lock clears open", outs(), LCK | GEN);
        wr(OPEN | GEN); rd(v); check("R4 open not settable", v, LCK | GEN);
        wr(8'h00); rd(v); check("R5 lock sticky", v, LCK | GEN);
        check("R6 gen frozen at 1", {7'd0, dec_global_en}, 8'h01);
        wr(CLS); rd(v); check("R7 closed set while locked", v, LCK | CLS | GEN);
        wr(8'h00); check("R7 closed clear while locked", outs(), LCK | GEN);
    endtask

    task automatic t_gen_frozen_zero();
        logic [7:0] v;
        do_reset();
        wr(LCK); wr(GEN | OPEN | LCK); rd(v); check("R6 gen frozen at 0", v, LCK);
    endtask

    task automatic t_relock_reset();
        logic [7:0] v;
        do_reset();
        check("R9 lock cleared", outs(), 8'h00);
        wr(OPEN); rd(v); check("R9 open settable again", v, OPEN);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_unlocked();
        do_reset();
        t_lock();
        t_gen_frozen_zero();
        t_relock_reset();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule